// File: doc/BRIEF.md
# Saturating Rounding Doubling Multiply-Subtract Unit

This unit performs packed signed fixed-point arithmetic on up to 128 bits of data. In each lane it forms the full-precision product of two signed elements and doubles it. It takes that doubled product away from an accumulator element that has been moved up by one lane width, adds half of one unit in the last place, and keeps the upper half of the sum. If that upper half does not fit in the lane, it is clamped to the nearest end of the lane's range. No intermediate step is saturated. Only the final high half is clamped.

A request is one strobe that carries three operand vectors and a set of controls. The controls select the lane width (16 or 32 bits), the vector width (64 or 128 bits), and the source of the multiplier. In vector mode every lane has its own multiplier. In scalar mode one indexed element is broadcast to every lane. The packed result, a flag for saturation in this operation, and a sticky saturation bit appear one clock later. The sticky bit can be cleared.

Top module: `srdms_unit`

## Requirements
- R1: Each lane produces clamp(((acc << W) − 2·a·b + 2^(W−1)) >>> W) at full precision, where W is the lane width. The operands a, b and acc are signed lane values, and there is no saturation before the final clamp.
- R2: The final shift is arithmetic, so an exact half rounds toward +∞. For example, with 16-bit lanes, a = 0xFFFF, b = 0x4000, acc = 0 gives 0x0001, and a = 0x0001, b = 0x4000, acc = 0 gives 0x0000.
- R3: A lane result above the maximum becomes 0x7FFF or 0x7FFFFFFF, and one below the minimum becomes 0x8000 or 0x80000000. `out_sat` is 1 exactly when at least one active lane was clamped.
- R4: `size_sel` = 2'b01 selects 16-bit lanes and 2'b10 selects 32-bit lanes. The codes 2'b00 and 2'b11 are illegal. An illegal strobe leaves `out_valid` and `out_sat` at 0, holds `out_result`, and does not set `sticky_sat`.
- R5: With `wide_mode` = 1 all 128 bits are processed. With `wide_mode` = 0 only bits 63:0 are processed, result bits 127:64 are 0, and the upper input lanes have no effect on `out_sat`.
- R6: With `scalar_mode` = 0, lane i uses lane i of `src_b` as its multiplier.
- R7: With `scalar_mode` = 1, the multiplier for every lane in both halves is one element of `src_b` bits 63:0. For 16-bit lanes, `scalar_idx` (values 0–3) picks the element. For 32-bit lanes, only `scalar_idx`[0] picks the element and bit 1 is ignored.
- R8: Lanes are packed little-endian. Lane 0 occupies the least significant W bits of the vector.
- R9: `out_result`, `out_sat` and `out_valid` change on the clock edge after the edge that samples a legal strobe. A cycle without a legal strobe gives `out_valid` = 0 and `out_sat` = 0 and holds `out_result`.
- R10: A saturating operation sets `sticky_sat`. Non-saturating operations never clear it. `sticky_clr` clears it on the next edge, but a saturating operation on the same edge wins and leaves it set.
- R11: After reset, `out_valid`, `out_sat` and `sticky_sat` are 0 and `out_result` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| size_sel | input | 2 | Lane width code (01 = 16-bit, 10 = 32-bit) |
| wide_mode | input | 1 | 1 = 128-bit operation, 0 = 64-bit operation |
| scalar_mode | input | 1 | 1 = broadcast an indexed multiplier to all lanes |
| scalar_idx | input | 2 | Element index of the broadcast multiplier |
| src_a | input | 128 | Multiplicand vector |
| src_b | input | 128 | Multiplier vector, or the scalar source in its low half |
| src_acc | input | 128 | Accumulator vector |
| sticky_clr | input | 1 | Synchronous clear of the sticky saturation bit |
| out_valid | output | 1 | Result valid |
| out_result | output | 128 | Packed result vector |
| out_sat | output | 1 | At least one lane saturated in this operation |
| sticky_sat | output | 1 | Cumulative saturation bit |

## Verification
The unit has only one register stage. A wrong internal value therefore reaches the ports on the edge after the strobe that caused it. Examples are a misrouted scalar element, a lane mask that lets the idle upper half contribute, or an intermediate value that is too narrow to hold the −2^(W−1)·−2^(W−1) product. The sticky bit is the only state that lasts across operations. A lost or spurious setting of it persists, and the next check of that bit shows it, including after an illegal strobe or a clear.

// File: rtl/srdms_pkg.sv
package srdms_pkg;

    localparam int DEF_VEC_W    = 128;
    localparam int DEF_NARROW_W = 16;
    localparam int DEF_WIDE_W   = 32;

    typedef enum logic [1:0] {
        LSZ_RSV0 = 2'b00,
        LSZ_HALF = 2'b01,
        LSZ_WORD = 2'b10,
        LSZ_RSV3 = 2'b11
    } lane_size_e;

endpackage

// File: rtl/srdms_lane.sv
module srdms_lane #(
    parameter  int W  = 16,
    localparam int IW = 2 * W + 3
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] acc_i,
    output logic [W-1:0] res_o,
    output logic         sat_o
);

    localparam logic signed [IW-1:0] ONE_X  = IW'(1);
    localparam logic signed [IW-1:0] RND_X  = ONE_X <<< (W - 1);
    localparam logic signed [IW-1:0] HI_LIM = RND_X - ONE_X;
    localparam logic signed [IW-1:0] LO_LIM = -RND_X;

    logic signed [IW-1:0] a_x, b_x, acc_x, prod_x, sum_x, high_x;

    always_comb begin
        a_x    = {{(IW - W){a_i[W-1]}}, a_i};
        b_x    = {{(IW - W){b_i[W-1]}}, b_i};
        acc_x  = {{(IW - W){acc_i[W-1]}}, acc_i};
        prod_x = a_x * b_x;
        sum_x  = (acc_x <<< W) - (prod_x <<< 1) + RND_X;
        high_x = sum_x >>> W;
        if (high_x > HI_LIM) begin
            res_o = HI_LIM[W-1:0];
            sat_o = 1'b1;
        end else if (high_x < LO_LIM) begin
            res_o = LO_LIM[W-1:0];
            sat_o = 1'b1;
        end else begin
            res_o = high_x[W-1:0];
            sat_o = 1'b0;
        end
    end

    // R3: a clamped lane must sit at one end of the lane range
    always_comb begin
        if (sat_o) begin
            a_r3_clamp_extreme: assert (res_o == {1'b0, {(W-1){1'b1}}} || res_o == {1'b1, {(W-1){1'b0}}});
        end
    end

endmodule

// File: rtl/srdms_bsel.sv
module srdms_bsel #(
    parameter  int VEC_W  = 128,
    parameter  int LANE_W = 16,
    parameter  int IDX_W  = 2,
    localparam int N_LANE = VEC_W / LANE_W,
    localparam int PER_HALF = (VEC_W / 2) / LANE_W
) (
    input  logic [VEC_W-1:0] b_i,
    input  logic             scalar_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [VEC_W-1:0] b_o
);

    logic [LANE_W-1:0] pick;

    always_comb begin
        pick = '0;
        for (int k = 0; k < PER_HALF; k++) begin
            if (idx_i == IDX_W'(k)) begin
                pick = b_i[k*LANE_W +: LANE_W];
            end
        end
        b_o = scalar_i ? {N_LANE{pick}} : b_i;
    end

endmodule

// File: rtl/srdms_lane_array.sv
module srdms_lane_array #(
    parameter  int VEC_W  = 128,
    parameter  int LANE_W = 16,
    parameter  int IDX_W  = 2,
    localparam int N_LANE = VEC_W / LANE_W
) (
    input  logic [VEC_W-1:0]  a_i,
    input  logic [VEC_W-1:0]  b_i,
    input  logic [VEC_W-1:0]  acc_i,
    input  logic              scalar_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [VEC_W-1:0]  res_o,
    output logic [N_LANE-1:0] sat_o
);

    logic [VEC_W-1:0] mult_v;

    srdms_bsel #(
        .VEC_W (VEC_W),
        .LANE_W(LANE_W),
        .IDX_W (IDX_W)
    ) bsel_i (
        .b_i     (b_i),
        .scalar_i(scalar_i),
        .idx_i   (idx_i),
        .b_o     (mult_v)
    );

    for (genvar i = 0; i < N_LANE; i++) begin : g_lane
        srdms_lane #(.W(LANE_W)) lane_i (
            .a_i  (a_i[i*LANE_W +: LANE_W]),
            .b_i  (mult_v[i*LANE_W +: LANE_W]),
            .acc_i(acc_i[i*LANE_W +: LANE_W]),
            .res_o(res_o[i*LANE_W +: LANE_W]),
            .sat_o(sat_o[i])
        );
    end

endmodule

// File: rtl/srdms_unit.sv
module srdms_unit
    import srdms_pkg::*;
#(
    parameter  int VEC_W    = DEF_VEC_W,
    parameter  int NARROW_W = DEF_NARROW_W,
    parameter  int WIDE_W   = DEF_WIDE_W,
    localparam int SIDX_W   = $clog2((VEC_W / 2) / NARROW_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        size_sel,
    input  logic              wide_mode,
    input  logic              scalar_mode,
    input  logic [SIDX_W-1:0] scalar_idx,
    input  logic [VEC_W-1:0]  src_a,
    input  logic [VEC_W-1:0]  src_b,
    input  logic [VEC_W-1:0]  src_acc,
    input  logic              sticky_clr,
    output logic              out_valid,
    output logic [VEC_W-1:0]  out_result,
    output logic              out_sat,
    output logic              sticky_sat
);

    localparam int HALF_W       = VEC_W / 2;
    localparam int N_NAR        = VEC_W / NARROW_W;
    localparam int N_WID        = VEC_W / WIDE_W;
    localparam int NAR_PER_HALF = HALF_W / NARROW_W;
    localparam int WID_PER_HALF = HALF_W / WIDE_W;
    localparam int WIDX_W       = $clog2(WID_PER_HALF);

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] result;
        logic             sat;
        logic             sticky;
    } unit_state_t;

    unit_state_t st_d, st_q;

    logic [VEC_W-1:0] res_n, res_w, sel_res;
    logic [N_NAR-1:0] sat_n, act_n;
    logic [N_WID-1:0] sat_w, act_w;
    logic             legal, use_word, any_sat;

    srdms_lane_array #(
        .VEC_W (VEC_W),
        .LANE_W(NARROW_W),
        .IDX_W (SIDX_W)
    ) nar_i (
        .a_i     (src_a),
        .b_i     (src_b),
        .acc_i   (src_acc),
        .scalar_i(scalar_mode),
        .idx_i   (scalar_idx),
        .res_o   (res_n),
        .sat_o   (sat_n)
    );

    srdms_lane_array #(
        .VEC_W (VEC_W),
        .LANE_W(WIDE_W),
        .IDX_W (WIDX_W)
    ) wid_i (
        .a_i     (src_a),
        .b_i     (src_b),
        .acc_i   (src_acc),
        .scalar_i(scalar_mode),
        .idx_i   (scalar_idx[WIDX_W-1:0]),
        .res_o   (res_w),
        .sat_o   (sat_w)
    );

    for (genvar i = 0; i < N_NAR; i++) begin : g_act_n
        if (i < NAR_PER_HALF) begin : g_lo
            assign act_n[i] = 1'b1;
        end else begin : g_hi
            assign act_n[i] = wide_mode;
        end
    end

    for (genvar i = 0; i < N_WID; i++) begin : g_act_w
        if (i < WID_PER_HALF) begin : g_lo
            assign act_w[i] = 1'b1;
        end else begin : g_hi
            assign act_w[i] = wide_mode;
        end
    end

    always_comb begin
        legal    = (size_sel == LSZ_HALF) || (size_sel == LSZ_WORD);
        use_word = (size_sel == LSZ_WORD);
        sel_res  = use_word ? res_w : res_n;
        if (!wide_mode) begin
            sel_res[VEC_W-1:HALF_W] = '0;
        end
        any_sat = use_word ? |(sat_w & act_w) : |(sat_n & act_n);

        st_d       = st_q;
        st_d.valid = in_valid && legal;
        st_d.sat   = 1'b0;
        if (st_d.valid) begin
            st_d.result = sel_res;
            st_d.sat    = any_sat;
        end
        st_d.sticky = (st_q.sticky && !sticky_clr) || st_d.sat;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.valid;
    assign out_result = st_q.result;
    assign out_sat    = st_q.sat;
    assign sticky_sat = st_q.sticky;

    // R9: a legal strobe yields a valid result on the next edge
    a_r9_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (size_sel == LSZ_HALF || size_sel == LSZ_WORD)) |=> out_valid);

    // R4: an illegal strobe holds the result and raises nothing
    a_r4_illegal_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (size_sel == LSZ_RSV0 || size_sel == LSZ_RSV3))
            |=> (!out_valid && !out_sat && $stable(out_result)));

    // R5: a 64-bit operation leaves the upper half at zero
    a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !wide_mode && (size_sel == LSZ_HALF || size_sel == LSZ_WORD))
            |=> (out_result[VEC_W-1:HALF_W] == '0));

    // R3: the per-operation flag only accompanies a valid result
    a_r3_sat_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_sat |-> out_valid);

    // R10: sticky bit is set whenever an operation saturates
    a_r10_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
        out_sat |-> sticky_sat);

    // R10: sticky bit only falls after a clear request
    a_r10_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sticky_sat) |-> $past(sticky_clr));

endmodule

// File: tb/srdms_unit_tb_top.sv
module srdms_unit_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   size_sel = 2'b01;
    logic         wide_mode = 1'b1;
    logic         scalar_mode = 1'b0;
    logic [1:0]   scalar_idx = 2'b00;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic [127:0] src_acc = '0;
    logic         sticky_clr = 1'b0;
    logic         out_valid;
    logic [127:0] out_result;
    logic         out_sat;
    logic         sticky_sat;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    srdms_unit dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .size_sel   (size_sel),
        .wide_mode  (wide_mode),
        .scalar_mode(scalar_mode),
        .scalar_idx (scalar_idx),
        .src_a      (src_a),
        .src_b      (src_b),
        .src_acc    (src_acc),
        .sticky_clr (sticky_clr),
        .out_valid  (out_valid),
        .out_result (out_result),
        .out_sat    (out_sat),
        .sticky_sat (sticky_sat)
    );

    // {a, b, acc, expected, sat} for one 16-bit lane, replicated over all lanes
    localparam logic [64:0] VEC16 [0:10] = '{
        {16'h8000, 16'h8000, 16'h0000, 16'h8000, 1'b0},
        {16'h8000, 16'h8000, 16'h8000, 16'h8000, 1'b1},
        {16'h8000, 16'h7FFF, 16'h7FFF, 16'h7FFF, 1'b1},
        {16'h0000, 16'h0000, 16'h1234, 16'h1234, 1'b0},
        {16'h4000, 16'h4000, 16'h0000, 16'hE000, 1'b0},
        {16'hFFFF, 16'h4000, 16'h0000, 16'h0001, 1'b0},
        {16'h0001, 16'h4000, 16'h0000, 16'h0000, 1'b0},
        {16'h0000, 16'h0000, 16'h7FFF, 16'h7FFF, 1'b0},
        {16'h0001, 16'h4000, 16'h8000, 16'h8000, 1'b0},
        {16'h0001, 16'h4001, 16'h8000, 16'h8000, 1'b1},
        {16'hFFFF, 16'h4000, 16'h7FFF, 16'h7FFF, 1'b1}
    };

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic op(input logic [1:0] sz, input bit wide, input bit scal, input logic [1:0] idx,
                      input logic [127:0] a, input logic [127:0] b, input logic [127:0] acc,
                      input bit vld, input bit clr);
        size_sel    = sz;
        wide_mode   = wide;
        scalar_mode = scal;
        scalar_idx  = idx;
        src_a       = a;
        src_b       = b;
        src_acc     = acc;
        in_valid    = vld;
        sticky_clr  = clr;
        @(posedge clk);
        @(negedge clk);
        in_valid    = 1'b0;
        sticky_clr  = 1'b0;
    endtask

    function automatic logic [128:0] ref_op(input bit w32, input bit wide, input bit scal,
                                            input logic [1:0] idx, input logic [127:0] a,
                                            input logic [127:0] b, input logic [127:0] acc);
        logic [127:0] r;
        bit s;
        int w, n, bi;
        logic signed [71:0] ax, bx, cx, t, lim;
        r = '0;
        s = 1'b0;
        w = w32 ? 32 : 16;
        n = (wide ? 128 : 64) / w;
        for (int i = 0; i < n; i++) begin
            bi = scal ? (w32 ? int'(idx[0]) : int'(idx)) : i;
            if (w32) begin
                ax = 72'($signed(a[i*32 +: 32]));
                bx = 72'($signed(b[bi*32 +: 32]));
                cx = 72'($signed(acc[i*32 +: 32]));
            end else begin
                ax = 72'($signed(a[i*16 +: 16]));
                bx = 72'($signed(b[bi*16 +: 16]));
                cx = 72'($signed(acc[i*16 +: 16]));
            end
            t   = ((cx <<< w) - 2 * ax * bx + (72'sd1 <<< (w - 1))) >>> w;
            lim = (72'sd1 <<< (w - 1)) - 72'sd1;
            if (t > lim) begin
                t = lim;
                s = 1'b1;
            end else if (t < -lim - 72'sd1) begin
                t = -lim - 72'sd1;
                s = 1'b1;
            end
            if (w32) r[i*32 +: 32] = t[31:0];
            else     r[i*16 +: 16] = t[15:0];
        end
        return {s, r};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [128:0] exp;
        logic [127:0] held;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        check("R11 valid", 128'(out_valid), 128'd0);
        check("R11 result", out_result, '0);
        check("R11 sat", 128'(out_sat), 128'd0);
        check("R11 sticky", 128'(sticky_sat), 128'd0);

        // R1 R2 R3 table of 16-bit corners, 128-bit vector mode
        foreach (VEC16[k]) begin
            op(2'b01, 1'b1, 1'b0, 2'd0, {8{VEC16[k][64:49]}}, {8{VEC16[k][48:33]}},
               {8{VEC16[k][32:17]}}, 1'b1, 1'b0);
            check("R1 table result", out_result, {8{VEC16[k][16:1]}});
            check("R3 table sat", 128'(out_sat), 128'(VEC16[k][0]));
            check("R9 table valid", 128'(out_valid), 128'd1);
        end

        // R9 no strobe: valid and sat drop, result held
        held = out_result;
        op(2'b01, 1'b1, 1'b0, 2'd0, '0, '0, '0, 1'b0, 1'b0);
        check("R9 idle valid", 128'(out_valid), 128'd0);
        check("R9 idle result", out_result, held);

        // R10 sticky clear alone, then non-saturating op keeps it clear
        check("R10 sticky set", 128'(sticky_sat), 128'd1);
        op(2'b01, 1'b1, 1'b0, 2'd0, '0, '0, '0, 1'b0, 1'b1);
        check("R10 cleared", 128'(sticky_sat), 128'd0);

        // R8 lane 0 in lowest bits
        op(2'b01, 1'b1, 1'b0, 2'd0, 128'hFFFF, 128'h4000, '0, 1'b1, 1'b0);
        check("R8 lane0 position", out_result, 128'h1);
        check("R10 stays clear", 128'(sticky_sat), 128'd0);

        // R1 R6 32-bit corners, vector mode
        begin
            logic [127:0] a, b, c;
            a = {32'h12345678, 32'h7FFFFFFF, 32'h80000000, 32'h80000000};
            b = {32'h9ABCDEF0, 32'h80000000, 32'h80000000, 32'h80000000};
            c = {32'h0F0F0F0F, 32'h7FFFFFFF, 32'h00000000, 32'h80000000};
            exp = ref_op(1'b1, 1'b1, 1'b0, 2'd0, a, b, c);
            op(2'b10, 1'b1, 1'b0, 2'd0, a, b, c, 1'b1, 1'b0);
            check("R6 word vector result", out_result, exp[127:0]);
            check("R3 word vector sat", 128'(out_sat), 128'(exp[128]));
            check("R3 word lane0 min", 128'(out_result[31:0]), 128'h80000000);
            check("R10 sticky after sat", 128'(sticky_sat), 128'd1);
        end

        // R10 non-saturating op does not clear sticky
        op(2'b10, 1'b1, 1'b0, 2'd0, '0, '0, '0, 1'b1, 1'b0);
        check("R10 hold on clean op", 128'(sticky_sat), 128'd1);

        // R10 clear and saturate on same edge: set wins
        op(2'b01, 1'b1, 1'b0, 2'd0, {8{16'h8000}}, {8{16'h8000}}, {8{16'h8000}}, 1'b1, 1'b1);
        check("R10 set wins", 128'(sticky_sat), 128'd1);
        op(2'b01, 1'b1, 1'b0, 2'd0, '0, '0, '0, 1'b0, 1'b1);
        check("R10 clear again", 128'(sticky_sat), 128'd0);

        // R7 scalar 16-bit, index 2, upper half of b ignored
        op(2'b01, 1'b1, 1'b1, 2'd2, {8{16'hFFFF}},
           {64'h7777777777777777, 16'h0000, 16'h4000, 16'h1111, 16'h2222}, '0, 1'b1, 1'b0);
        check("R7 half scalar", out_result, {8{16'h0001}});

        // R7 scalar 32-bit, index bit 1 ignored
        op(2'b10, 1'b1, 1'b1, 2'd3, {4{32'hFFFFFFFF}},
           {64'h7FFFFFFF7FFFFFFF, 32'h40000000, 32'h00000005}, '0, 1'b1, 1'b0);
        check("R7 word scalar", out_result, {4{32'h00000001}});

        // R7 scalar 16-bit mixed pattern against model
        begin
            logic [127:0] a, b, c;
            a = 128'h8000_7FFF_1234_F00D_0001_8000_4000_C000;
            b = 128'h0000_0000_0000_0000_8000_2468_7FFF_ABCD;
            c = 128'h7FFF_8000_0000_1111_8000_7FFF_0000_2222;
            exp = ref_op(1'b0, 1'b1, 1'b1, 2'd3, a, b, c);
            op(2'b01, 1'b1, 1'b1, 2'd3, a, b, c, 1'b1, 1'b0);
            check("R7 half scalar idx3", out_result, exp[127:0]);
            check("R3 half scalar sat", 128'(out_sat), 128'(exp[128]));
        end

        // R5 64-bit op: upper lanes would saturate but are ignored
        op(2'b00, 1'b0, 1'b0, 2'd0, '0, '0, '0, 1'b0, 1'b1);
        op(2'b01, 1'b0, 1'b0, 2'd0, {8{16'h8000}}, {8{16'h8000}},
           {{4{16'h8000}}, 64'h0}, 1'b1, 1'b0);
        check("R5 narrow result", out_result, {64'h0, {4{16'h8000}}});
        check("R5 narrow sat", 128'(out_sat), 128'd0);
        check("R5 narrow sticky", 128'(sticky_sat), 128'd0);

        // R4 illegal size codes: nothing written
        held = out_result;
        op(2'b00, 1'b1, 1'b0, 2'd0, {8{16'h8000}}, {8{16'h8000}}, {8{16'h8000}}, 1'b1, 1'b0);
        check("R4 code00 valid", 128'(out_valid), 128'd0);
        check("R4 code00 result", out_result, held);
        check("R4 code00 sticky", 128'(sticky_sat), 128'd0);
        op(2'b11, 1'b1, 1'b0, 2'd0, {8{16'h8000}}, {8{16'h8000}}, {8{16'h8000}}, 1'b1, 1'b0);
        check("R4 code11 valid", 128'(out_valid), 128'd0);
        check("R4 code11 sat", 128'(out_sat), 128'd0);
        check("R4 code11 result", out_result, held);
        check("R4 code11 sticky", 128'(sticky_sat), 128'd0);

        // R2 rounding in 32-bit lanes, 64-bit op
        op(2'b10, 1'b0, 1'b0, 2'd0, {64'h0, 32'h00000001, 32'hFFFFFFFF},
           {64'h0, 32'h40000000, 32'h40000000}, '0, 1'b1, 1'b0);
        check("R2 word rounding", out_result, {64'h0, 32'h00000000, 32'h00000001});

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule